// File: doc/BRIEF.md
# Signed-Digit Coefficient Multiply-Accumulate Unit

This block is a pipelined multiply-accumulate engine. Its coefficient operand does not arrive as a plain binary number. It arrives as a packed string of 2-bit radix-4 digit codes, encoded ahead of time and read from coefficient storage. Each digit takes one of only four values. Because of that, every partial-product row is a mux over zero, once or twice the multiplicand, plus an optional inversion, and no recoding logic sits in the datapath. An N-bit code word gives N/2 rows. The negation carries are gathered into one extra row, and a carry-save tree reduces all the rows to a sum and a carry word.

Each beat is qualified by a valid strobe. Three pipeline stages follow: row generation with the carry-save tree, then a 2N-bit carry-propagate add, then the accumulator. A per-beat variant select chooses which of the two four-value digit sets the codes are read in. A clear flag on a beat restarts the running sum with that beat's product.

Top module: `nrsd_mac`

## Requirements
- R1: Digit j sits in bits [2j+1:2j] of `in_digits`. Code 00 means 0, 01 means +1 and 10 means -1. Code 11 means -2 when `in_plus` is 0 and +2 when `in_plus` is 1.
- R2: The product of a beat is signed(`in_mcand`) times the sum over j of digit_j·4^j, formed exactly in 2N bits.
- R3: A beat sampled at clock edge k shows its result on `acc_out` with `acc_valid` high right after edge k+2. Every valid beat gives exactly one `acc_valid` cycle, and no other cycle has one.
- R4: A valid beat without clear adds its product to the accumulator.
- R5: A valid beat with `in_clear` high loads the accumulator with that beat's product and drops the previous sum.
- R6: When `acc_valid` is low, `acc_out` does not change. `in_clear`, `in_mcand`, `in_digits` and `in_plus` have no effect while `in_valid` is low.
- R7: While `rst_n` is low, `acc_out` is 0 and `acc_valid` is 0.
- R8: Valid beats on consecutive cycles are all accumulated, one result per cycle.
- R9: Accumulation wraps modulo 2^(2N) and never saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat qualifier |
| in_mcand | input | N | Two's-complement multiplicand |
| in_digits | input | N | N/2 packed 2-bit digit codes, least significant digit in the low bits |
| in_clear | input | 1 | Restart the sum with this beat's product |
| in_plus | input | 1 | Digit-set select for code 11 (0: -2, 1: +2) |
| acc_out | output | 2N | Running sum |
| acc_valid | output | 1 | Pulses high for one cycle when `acc_out` takes a new beat |

## Verification
The checker assumes that `in_valid` and `in_clear` are never unknown outside reset and that `rst_n` starts low, so the reset property holds from the first edge. Every 2-bit code is legal, so the digit inputs need no assumption. The coefficient range follows from the digit set in use. The stimulus drives all inputs just after the falling edge. It sweeps every code word in both digit sets against a fixed list of multiplicands. Random coefficients are produced by a reference encoder that stays inside the set's range. The sequence also includes idle cycles where the ignored inputs toggle, and it drains the pipeline before it asserts reset again.

// File: rtl/nrsd_mac_pkg.sv
package nrsd_mac_pkg;

   typedef struct packed {
      logic zero;
      logic two;
      logic neg;
   } nrsd_sel_t;

   // map one 2-bit digit code onto a row selection
   function automatic nrsd_sel_t nrsd_decode(input logic [1:0] code, input logic plus);
      nrsd_sel_t s;
      s = '0;
      case (code)
         2'b00: s.zero = 1'b1;
         2'b01: s.neg  = 1'b0;
         2'b10: s.neg  = 1'b1;
         default: begin
            s.two = 1'b1;
            s.neg = ~plus;
         end
      endcase
      return s;
   endfunction

   function automatic int unsigned csa_next(input int unsigned m);
      return 2 * (m / 3) + (m % 3);
   endfunction

   function automatic int unsigned csa_rows_at(input int unsigned m, input int unsigned lv);
      int unsigned r;
      r = m;
      for (int unsigned i = 0; i < lv; i++) r = csa_next(r);
      return r;
   endfunction

   function automatic int unsigned csa_levels(input int unsigned m);
      int unsigned r;
      int unsigned l;
      r = m;
      l = 0;
      while (r > 2) begin
         r = csa_next(r);
         l++;
      end
      return l;
   endfunction

endpackage

// File: rtl/nrsd_pp_rows.sv
module nrsd_pp_rows
   import nrsd_mac_pkg::*;
#(
   parameter int unsigned N = 8,
   localparam int unsigned W = 2 * N,
   localparam int unsigned K = N / 2
) (
   input  logic [N-1:0]       mcand,
   input  logic [N-1:0]       digits,
   input  logic               plus,
   output logic [K:0][W-1:0]  rows
);

   logic [W-1:0] ext;
   logic [K-1:0] neg_bits;

   assign ext = {{(W-N){mcand[N-1]}}, mcand};

   for (genvar j = 0; j < K; j++) begin : g_row
      nrsd_sel_t    sel;
      logic [W-1:0] mag;
      logic [W-1:0] inv;

      assign sel = nrsd_decode(digits[2*j +: 2], plus);
      assign mag = sel.zero ? '0 : (sel.two ? (ext << 1) : ext);
      assign inv = (sel.neg && !sel.zero) ? ~mag : mag;
      assign rows[j] = inv << (2 * j);
      assign neg_bits[j] = sel.neg && !sel.zero;
   end

   // negation carries: one bit at position 2j per row, gathered into the last row
   always_comb begin
      rows[K] = '0;
      for (int unsigned j = 0; j < K; j++) rows[K][2*j] = neg_bits[j];
   end

endmodule

// File: rtl/nrsd_csa_tree.sv
module nrsd_csa_tree
   import nrsd_mac_pkg::*;
#(
   parameter int unsigned W    = 16,
   parameter int unsigned ROWS = 5,
   localparam int unsigned LEVELS = csa_levels(ROWS)
) (
   input  logic [ROWS-1:0][W-1:0] rows_in,
   output logic [W-1:0]           sum_o,
   output logic [W-1:0]           carry_o
);

   logic [W-1:0] lvl [0:LEVELS][0:ROWS-1];

   for (genvar i = 0; i < ROWS; i++) begin : g_in
      assign lvl[0][i] = rows_in[i];
   end

   for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
      localparam int unsigned M  = csa_rows_at(ROWS, lv);
      localparam int unsigned G  = M / 3;
      localparam int unsigned MN = csa_next(M);

      for (genvar i = 0; i < ROWS; i++) begin : g_slot
         if (i < 3 * G && (i % 3) == 0) begin : g_csa
            logic [W-1:0] a, b, c;
            assign a = lvl[lv][i];
            assign b = lvl[lv][i+1];
            assign c = lvl[lv][i+2];
            assign lvl[lv+1][2*(i/3)]   = a ^ b ^ c;
            assign lvl[lv+1][2*(i/3)+1] = ((a & b) | (a & c) | (b & c)) << 1;
         end else if (i >= 3 * G && i < M) begin : g_pass
            assign lvl[lv+1][2*G + i - 3*G] = lvl[lv][i];
         end
      end

      for (genvar k = MN; k < ROWS; k++) begin : g_zero
         assign lvl[lv+1][k] = '0;
      end
   end

   assign sum_o   = lvl[LEVELS][0];
   assign carry_o = lvl[LEVELS][1];

endmodule

// File: rtl/nrsd_accum.sv
module nrsd_accum #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         prod_vld,
   input  logic         prod_clr,
   input  logic [W-1:0] prod,
   output logic [W-1:0] acc,
   output logic         acc_vld
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         acc_vld <= 1'b0;
      end else begin
         acc_vld <= prod_vld;
         if (prod_vld) acc <= prod_clr ? prod : acc + prod;
      end
   end

endmodule

// File: rtl/nrsd_mac.sv
module nrsd_mac #(
   parameter int unsigned N = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [N-1:0]   in_mcand,
   input  logic [N-1:0]   in_digits,
   input  logic           in_clear,
   input  logic           in_plus,
   output logic [2*N-1:0] acc_out,
   output logic           acc_valid
);

   localparam int unsigned W    = 2 * N;
   localparam int unsigned K    = N / 2;
   localparam int unsigned ROWS = K + 1;

   if ((N % 2) != 0 || N < 4) begin : g_bad_n
      $error("nrsd_mac: N must be even and at least 4");
   end

   logic [K:0][W-1:0] rows;
   logic [W-1:0]      t_sum, t_carry;
   logic [W-1:0]      s1_sum, s1_carry, s2_prod;
   logic              s1_vld, s1_clr, s2_vld, s2_clr;

   nrsd_pp_rows #(.N(N)) u_rows (
      .mcand  (in_mcand),
      .digits (in_digits),
      .plus   (in_plus),
      .rows   (rows)
   );

   nrsd_csa_tree #(.W(W), .ROWS(ROWS)) u_tree (
      .rows_in (rows),
      .sum_o   (t_sum),
      .carry_o (t_carry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s2_vld <= 1'b0;
      end else begin
         s1_vld <= in_valid;
         s2_vld <= s1_vld;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         s1_sum   <= t_sum;
         s1_carry <= t_carry;
         s1_clr   <= in_clear;
      end
      if (s1_vld) begin
         s2_prod <= s1_sum + s1_carry;
         s2_clr  <= s1_clr;
      end
   end

   nrsd_accum #(.W(W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .prod_vld (s2_vld),
      .prod_clr (s2_clr),
      .prod     (s2_prod),
      .acc      (acc_out),
      .acc_vld  (acc_valid)
   );

endmodule

// File: rtl/nrsd_mac_chk.sv
module nrsd_mac_chk #(
   parameter int unsigned N = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic [N-1:0]   in_mcand,
   input logic [N-1:0]   in_digits,
   input logic           in_clear,
   input logic [2*N-1:0] acc_out,
   input logic           acc_valid
);

   p_reset_state_r7: assert property (@(posedge clk)
      !rst_n |=> (acc_out == '0 && !acc_valid));

   p_result_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##3 acc_valid);

   p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##3 !acc_valid);

   p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> $stable(acc_out));

   p_zero_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_clear && (in_mcand == '0 || in_digits == '0)) |-> ##3 (acc_out == '0));

endmodule

bind nrsd_mac nrsd_mac_chk #(.N(N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_mcand  (in_mcand),
   .in_digits (in_digits),
   .in_clear  (in_clear),
   .acc_out   (acc_out),
   .acc_valid (acc_valid)
);

// File: tb/sim_nrsd_mac.sv
module sim_nrsd_mac;

   localparam int N  = 8;
   localparam int W  = 2 * N;
   localparam int K  = N / 2;
   localparam int QD = 16384;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [N-1:0] in_mcand = '0;
   logic [N-1:0] in_digits = '0;
   logic         in_clear = 1'b0;
   logic         in_plus = 1'b0;
   logic [W-1:0] acc_out;
   logic         acc_valid;

   int checks = 0;
   int fails = 0;
   int wr = 0;
   int rd = 0;
   logic [W-1:0] exp_q [0:QD-1];
   logic [W-1:0] model = '0;
   logic [W-1:0] last = '0;
   string cur_req = "R7";

   always #10 clk = ~clk;

   nrsd_mac #(.N(N)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_mcand  (in_mcand),
      .in_digits (in_digits),
      .in_clear  (in_clear),
      .in_plus   (in_plus),
      .acc_out   (acc_out),
      .acc_valid (acc_valid)
   );

   // digit values as stated in R1
   function automatic int coef_of(input logic [N-1:0] d, input logic plus);
      int c;
      int v;
      c = 0;
      for (int j = 0; j < K; j++) begin
         case (d[2*j +: 2])
            2'b00: v = 0;
            2'b01: v = 1;
            2'b10: v = -1;
            default: v = plus ? 2 : -2;
         endcase
         c += v * (1 << (2 * j));
      end
      return c;
   endfunction

   // reference encoder: least significant digit first, residue mod 4 picks the digit
   function automatic logic [N-1:0] encode(input int c_in, input logic plus);
      logic [N-1:0] d;
      int c;
      int v;
      c = c_in;
      d = '0;
      for (int j = 0; j < K; j++) begin
         case (c & 3)
            0: begin v = 0;  d[2*j +: 2] = 2'b00; end
            1: begin v = 1;  d[2*j +: 2] = 2'b01; end
            2: begin v = plus ? 2 : -2; d[2*j +: 2] = 2'b11; end
            default: begin v = -1; d[2*j +: 2] = 2'b10; end
         endcase
         c = (c - v) / 4;
      end
      return d;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one cycle of inputs; called just after a falling edge, returns at the next one
   task automatic drive(input logic v, input logic [N-1:0] x, input logic [N-1:0] d,
                        input logic clr, input logic plus);
      logic [W-1:0] p;
      in_valid  = v;
      in_mcand  = x;
      in_digits = d;
      in_clear  = clr;
      in_plus   = plus;
      if (v) begin
         p = W'($signed(x) * coef_of(d, plus));
         model = clr ? p : model + p;
         exp_q[wr % QD] = model;
         wr++;
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, N'($urandom), N'($urandom), 1'b1, 1'($urandom));
   endtask

   // compare every result beat; between beats the sum must hold (R6)
   always @(negedge clk) begin
      if (rst_n) begin
         if (acc_valid) begin
            check(cur_req, acc_out, exp_q[rd % QD]);
            last = exp_q[rd % QD];
            rd++;
         end else begin
            check("R6 hold", acc_out, last);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic [N-1:0] xs [0:15];
      xs[0] = 8'h00; xs[1] = 8'h01; xs[2] = 8'hFF; xs[3] = 8'h7F;
      xs[4] = 8'h80; xs[5] = 8'h02; xs[6] = 8'h55; xs[7] = 8'hAA;
      xs[8] = 8'h33; xs[9] = 8'hC3; xs[10] = 8'h0F; xs[11] = 8'hF0;
      xs[12] = 8'h7E; xs[13] = 8'h81; xs[14] = 8'h40; xs[15] = 8'hBF;

      // R7: outputs held at zero during reset
      repeat (2) @(negedge clk);
      check("R7 acc", acc_out, '0);
      check("R7 valid", W'(acc_valid), '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: single beat appears after exactly three edges
      cur_req = "R3";
      drive(1'b1, 8'h05, 8'h01, 1'b1, 1'b0);
      in_valid = 1'b0;
      check("R3 not yet", W'(acc_valid), '0);
      @(negedge clk);
      check("R3 not yet", W'(acc_valid), '0);
      @(negedge clk);
      check("R3 arrives", W'(acc_valid), 1);
      idle(3);

      // R1 R2 R5: every code word in both digit sets, each beat cleared so acc equals product
      cur_req = "R1 R2 R5 sweep";
      for (int pl = 0; pl < 2; pl++)
         for (int d = 0; d < 256; d++)
            for (int xi = 0; xi < 16; xi++)
               drive(1'b1, xs[xi], N'(d), 1'b1, 1'(pl));
      idle(4);

      // R9: repeated maximum positive products wrap past the top of the range
      cur_req = "R9 wrap";
      drive(1'b1, 8'h7F, 8'hFF, 1'b1, 1'b1);
      for (int i = 0; i < 9; i++) drive(1'b1, 8'h7F, 8'hFF, 1'b0, 1'b1);
      for (int i = 0; i < 6; i++) drive(1'b1, 8'h80, 8'hFF, 1'b0, 1'b0);
      idle(4);

      // R4 R8 R5 R6: encoded random coefficients, back-to-back beats, gaps with ignored inputs
      cur_req = "R4 R8 random";
      for (int i = 0; i < 2000; i++) begin
         logic pl;
         int c;
         pl = 1'($urandom);
         c = pl ? (int'($urandom_range(255)) - 85) : (int'($urandom_range(255)) - 170);
         if ($urandom_range(3) != 0)
            drive(1'b1, N'($urandom), encode(c, pl), ($urandom_range(15) == 0), pl);
         else
            idle(1);
      end
      idle(4);
      check("R3 one result per beat", W'(rd), W'(wr));

      // R7: reset after activity clears the sum
      cur_req = "R7";
      rst_n = 1'b0;
      model = '0;
      last = '0;
      @(negedge clk);
      check("R7 acc", acc_out, '0);
      check("R7 valid", W'(acc_valid), '0);
      rst_n = 1'b1;
      cur_req = "R4 after reset";
      drive(1'b1, 8'h03, encode(-7, 1'b0), 1'b0, 1'b0);
      drive(1'b1, 8'hFD, encode(9, 1'b1), 1'b0, 1'b1);
      idle(4);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule